// File: doc/BRIEF.md
# Frame-Buffer Register Slave over SPI

This block lets a host reach a camera frame buffer through a serial link, one byte per chip-select frame in SPI mode 0 (MSB first, data sampled on the rising SCK edge and shifted out on the falling edge). The host talks to a few byte-wide registers:
- three byte registers that together form a 24-bit memory pointer;
- a control register that requests a freeze of buffer updates;
- a status register that reports whether the freeze has settled;
- a data port that reads or writes the buffer at the pointer and can step the pointer.

SCK, MOSI and the active-low chip select are sampled by the system clock through two-flop synchronisers.

The slave returns read data one command late. The byte shifted out during any frame is the result of the most recent read command. A host therefore reads a burst of buffer bytes by sending the same data-port read command repeatedly and discarding the first returned byte. Before a transfer the host sets the freeze bit and then polls status until it reports the paused code. While the freeze is settled, writes from the capture side are dropped. A behavioural byte array stands in for the frame memory. Its capture-side write port is a plain enable, address and data input.

Top module: `camspi_regslave`

Link states: `LK_IDLE` (chip select high) goes to `LK_SHIFT` when chip select falls and loads the held read byte. `LK_SHIFT` goes to `LK_FULL` on the eighth rising SCK edge, which delivers the byte. Any state returns to `LK_IDLE` when chip select rises. Command states: `ST_CMD` goes to `ST_VAL` on a write command byte. `ST_VAL` goes back to `ST_CMD` on the value byte. A read command stays in `ST_CMD`. Pause states: `PS_RUN` goes to `PS_ENTER` on a freeze request. `PS_ENTER` goes to `PS_HOLD` when the settle timer expires, or back to `PS_RUN` if a release arrives first. `PS_HOLD` goes to `PS_LEAVE` on a release. `PS_LEAVE` goes to `PS_RUN` when the timer expires, or back to `PS_HOLD` if a freeze arrives first.

## Requirements
- R1: A command byte reads when bit 7 is 1 and writes when bit 7 is 0. Bits 3:0 select the register. Bits 6 and 4 are ignored.
- R2: A write is a command frame followed by a value frame. Registers 0x0, 0x1 and 0x2 hold pointer bits 7:0, 15:8 and 23:16, and read back what was written.
- R3: The byte shifted out in any frame is the result of the latest read command. Write command frames and value frames leave that byte unchanged.
- R4: A read of data port 0x8 returns the buffer byte at the pointer (pointer modulo buffer depth). If command bit 5 is set, the pointer then steps by one; otherwise it is unchanged.
- R5: A write to data port 0x8 stores the value at the pointer, with the same bit-5 stepping rule as R4.
- R6: The pointer wraps from 0xFFFFFF to 0x000000.
- R7: Command bit 5 has no effect on the pointer for any register other than the data port.
- R8: Writing 0x01 to control register 0x3 requests a freeze and writing 0x00 releases it. Bit 0 of control reads back the latest request.
- R9: Status register 0x4 reads 0x50 while updating and 0x51 while frozen. A change takes effect SETTLE_CYC clock cycles after the control value byte, and status shows only these two codes.
- R10: A capture-side write reaches the buffer only while status reads 0x50. While status reads 0x51 it is dropped.
- R11: Registers other than 0x0 to 0x4 and 0x8 read as 0x00, and writes to them change nothing.
- R12: Each byte needs its own chip-select frame. A frame that ends before eight SCK rising edges is discarded without effect.
- R13: After reset the pointer is 0, control is 0x00, status reads 0x50 and the held read byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Active-low chip select, one frame per byte |
| spi_miso | output | 1 | Serial data to host |
| cap_we | input | 1 | Capture-side buffer write enable |
| cap_addr | input | MEM_AW | Capture-side buffer address |
| cap_data | input | 8 | Capture-side buffer write data |

## Verification
An error in the held read byte shows on MISO one frame later, because every frame shifts out that byte. A wrong pointer step shows in the very next data-port read, or when the three pointer bytes are read back. A stuck pause state shows as a status poll that never reaches the target code within the expected number of frames. It also shows as a capture write that lands while frozen, which the next data-port read exposes. The reference model tracks the pointer, the buffer contents and the pending read result per frame, so the first diverging byte is reported in the frame where it appears.

// File: rtl/camspi_pkg.sv
package camspi_pkg;
    localparam int BYTE_W      = 8;
    localparam int PTR_BYTES   = 3;
    localparam int PTR_W       = PTR_BYTES * BYTE_W;
    localparam int IDX_W       = 4;
    localparam int CMD_DIR_BIT = 7;
    localparam int CMD_INC_BIT = 5;

    localparam logic [IDX_W-1:0] IDX_CTRL = 4'h3;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'h4;
    localparam logic [IDX_W-1:0] IDX_DATA = 4'h8;

    localparam logic [BYTE_W-1:0] STAT_BASE = 8'h50;

    typedef enum logic [1:0] {LK_IDLE, LK_SHIFT, LK_FULL} link_state_t;
    typedef enum logic {ST_CMD, ST_VAL} cmd_state_t;
    typedef enum logic [1:0] {PS_RUN, PS_ENTER, PS_HOLD, PS_LEAVE} pause_state_t;
endpackage

// File: rtl/camspi_link.sv
module camspi_link
    import camspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              csn,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [1:0] sck_q, mosi_q, csn_q;
    logic       sck_d;
    logic       sck_rise, sck_fall, frame_on;

    link_state_t      state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;

    // two-flop synchronisers on every link input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            mosi_q <= '0;
            csn_q  <= 2'b11;
            sck_d  <= 1'b0;
        end else begin
            sck_q  <= {sck_q[0], sck};
            mosi_q <= {mosi_q[0], mosi};
            csn_q  <= {csn_q[0], csn};
            sck_d  <= sck_q[1];
        end
    end

    assign sck_rise = sck_q[1] & ~sck_d;
    assign sck_fall = ~sck_q[1] & sck_d;
    assign frame_on = ~csn_q[1];

    always_comb begin
        state_nx = state;
        if (!frame_on) begin
            state_nx = LK_IDLE;
        end else begin
            unique case (state)
                LK_IDLE:  state_nx = LK_SHIFT;
                LK_SHIFT: if (sck_rise && bit_cnt == CNT_W'(BYTE_W - 1)) state_nx = LK_FULL;
                LK_FULL:  state_nx = LK_FULL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_IDLE;
        else        state <= state_nx;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (state == LK_IDLE && frame_on) begin
                tx_sh   <= tx_byte;
                bit_cnt <= '0;
            end else if (state == LK_SHIFT) begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_q[1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        rx_byte  <= {rx_sh[BYTE_W-2:0], mosi_q[1]};
                        rx_valid <= 1'b1;
                    end
                end
                if (sck_fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        miso = tx_sh[BYTE_W-1];
    end

    AST_ONE_BYTE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (!rx_valid && state != LK_SHIFT)); // R12
endmodule

// File: rtl/camspi_pause.sv
module camspi_pause
    import camspi_pkg::*;
#(
    parameter int SETTLE_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_val,
    output logic ctl_req,
    output logic stat_ready
);
    localparam int TW = $clog2(SETTLE_CYC + 1);

    pause_state_t  state, state_nx;
    logic [TW-1:0] timer;
    logic          load;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            PS_RUN: begin
                if (ctl_wr && ctl_val) begin
                    state_nx = PS_ENTER;
                    load     = 1'b1;
                end
            end
            PS_ENTER: begin
                if (ctl_wr && !ctl_val)        state_nx = PS_RUN;
                else if (ctl_wr)               load = 1'b1;
                else if (timer == TW'(1))      state_nx = PS_HOLD;
            end
            PS_HOLD: begin
                if (ctl_wr && !ctl_val) begin
                    state_nx = PS_LEAVE;
                    load     = 1'b1;
                end
            end
            PS_LEAVE: begin
                if (ctl_wr && ctl_val)         state_nx = PS_HOLD;
                else if (ctl_wr)               load = 1'b1;
                else if (timer == TW'(1))      state_nx = PS_RUN;
            end
        endcase
    end

    // state register, settle timer and request bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PS_RUN;
            timer   <= '0;
            ctl_req <= 1'b0;
        end else begin
            state <= state_nx;
            if (load)             timer <= TW'(SETTLE_CYC);
            else if (timer != '0) timer <= timer - 1'b1;
            if (ctl_wr)           ctl_req <= ctl_val;
        end
    end

    // outputs
    always_comb begin
        stat_ready = (state == PS_HOLD) || (state == PS_LEAVE);
    end

    AST_READY_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ready != $past(stat_ready)) |-> (stat_ready == ctl_req)); // R9
    AST_SETTLED_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN || state == PS_HOLD) |-> (stat_ready == ctl_req)); // R8
endmodule

// File: rtl/camspi_fbmem.sv
module camspi_fbmem
    import camspi_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [MEM_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              cap_we,
    input  logic              cap_block,
    input  logic [MEM_AW-1:0] cap_addr,
    input  logic [BYTE_W-1:0] cap_data,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    // host port wins over the capture port in the same cycle
    always_ff @(posedge clk) begin
        if (host_we)                   mem[host_addr] <= host_data;
        else if (cap_we && !cap_block) mem[cap_addr]  <= cap_data;
    end

    assign rd_data = mem[host_addr];
endmodule

// File: rtl/camspi_core.sv
module camspi_core
    import camspi_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              ctl_wr,
    output logic              ctl_val,
    input  logic              ctl_req,
    input  logic              stat_ready
);
    cmd_state_t        state, state_nx;
    logic [PTR_W-1:0]  ptr;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_inc;
    logic [BYTE_W-1:0] rdbuf;
    logic [BYTE_W-1:0] rd_val;

    logic             cmd_is_rd, cmd_inc;
    logic [IDX_W-1:0] cmd_idx;
    logic             rd_fire, wr_open, val_fire, step_ptr;

    assign cmd_is_rd = rx_byte[CMD_DIR_BIT];
    assign cmd_inc   = rx_byte[CMD_INC_BIT];
    assign cmd_idx   = rx_byte[IDX_W-1:0];
    assign rd_fire   = rx_valid && state == ST_CMD && cmd_is_rd;
    assign wr_open   = rx_valid && state == ST_CMD && !cmd_is_rd;
    assign val_fire  = rx_valid && state == ST_VAL;
    assign step_ptr  = (rd_fire && cmd_idx == IDX_DATA && cmd_inc) ||
                       (val_fire && wr_idx == IDX_DATA && wr_inc);

    // read multiplexer for the register selected by a read command
    always_comb begin
        rd_val = '0;
        if (cmd_idx < IDX_W'(PTR_BYTES)) begin
            for (int b = 0; b < PTR_BYTES; b++)
                if (cmd_idx == IDX_W'(b)) rd_val = ptr[b*BYTE_W +: BYTE_W];
        end else begin
            unique case (cmd_idx)
                IDX_CTRL: rd_val = {{(BYTE_W-1){1'b0}}, ctl_req};
                IDX_STAT: rd_val = STAT_BASE | {{(BYTE_W-1){1'b0}}, stat_ready};
                IDX_DATA: rd_val = mem_rdata;
                default:  rd_val = '0;
            endcase
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CMD: if (wr_open)  state_nx = ST_VAL;
            ST_VAL: if (val_fire) state_nx = ST_CMD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= state_nx;
    end

    // register file and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            wr_idx <= '0;
            wr_inc <= 1'b0;
            rdbuf  <= '0;
        end else begin
            if (rd_fire) rdbuf <= rd_val;
            if (wr_open) begin
                wr_idx <= cmd_idx;
                wr_inc <= cmd_inc;
            end
            if (val_fire) begin
                for (int b = 0; b < PTR_BYTES; b++)
                    if (wr_idx == IDX_W'(b)) ptr[b*BYTE_W +: BYTE_W] <= rx_byte;
            end
            if (step_ptr) ptr <= ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_byte   = rdbuf;
        mem_addr  = ptr[MEM_AW-1:0];
        mem_we    = val_fire && wr_idx == IDX_DATA;
        mem_wdata = rx_byte;
        ctl_wr    = val_fire && wr_idx == IDX_CTRL;
        ctl_val   = rx_byte[0];
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && state == ST_CMD && cmd_is_rd && cmd_idx == IDX_DATA && cmd_inc)
        |=> (ptr == PTR_W'($past(ptr) + 1'b1))); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && state == ST_CMD && !(cmd_is_rd && cmd_idx == IDX_DATA))
        |=> $stable(ptr)); // R7
    AST_RDBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && state == ST_VAL) |=> $stable(tx_byte)); // R3
endmodule

// File: rtl/camspi_regslave.sv
module camspi_regslave
    import camspi_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int SETTLE_CYC = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_csn,
    output logic              spi_miso,
    input  logic              cap_we,
    input  logic [MEM_AW-1:0] cap_addr,
    input  logic [BYTE_W-1:0] cap_data
);
    logic [BYTE_W-1:0] rx_byte, tx_byte, mem_rdata, mem_wdata;
    logic              rx_valid, mem_we, ctl_wr, ctl_val, ctl_req, stat_ready;
    logic [MEM_AW-1:0] mem_addr;

    camspi_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .csn      (spi_csn),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    camspi_core #(.MEM_AW(MEM_AW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .tx_byte    (tx_byte),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .ctl_wr     (ctl_wr),
        .ctl_val    (ctl_val),
        .ctl_req    (ctl_req),
        .stat_ready (stat_ready)
    );

    camspi_pause #(.SETTLE_CYC(SETTLE_CYC)) u_pause (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_val    (ctl_val),
        .ctl_req    (ctl_req),
        .stat_ready (stat_ready)
    );

    camspi_fbmem #(.MEM_AW(MEM_AW)) u_mem (
        .clk       (clk),
        .host_we   (mem_we),
        .host_addr (mem_addr),
        .host_data (mem_wdata),
        .cap_we    (cap_we),
        .cap_block (stat_ready),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .rd_data   (mem_rdata)
    );
endmodule

// File: tb/camspi_regslave_bench.sv
module camspi_regslave_bench;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1;
    logic       spi_miso;
    logic       cap_we = 1'b0;
    logic [7:0] cap_addr = '0, cap_data = '0;

    int tests = 0;
    int fails = 0;

    // behavioural reference model
    logic [7:0]  m_mem [256];
    logic [23:0] m_ptr = '0;
    logic        m_req = 1'b0;
    logic        m_ready = 1'b0;
    logic [7:0]  prev_exp = 8'h00;

    always #10 clk = ~clk;

    camspi_regslave u_camspi_regslave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_csn(spi_csn), .spi_miso(spi_miso), .cap_we(cap_we),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        @(negedge clk) spi_csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer_partial(input logic [7:0] tx, input int nbits);
        @(negedge clk) spi_csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] cmd);
        logic [7:0] r;
        case (cmd[3:0])
            4'h0: r = m_ptr[7:0];
            4'h1: r = m_ptr[15:8];
            4'h2: r = m_ptr[23:16];
            4'h3: r = {7'd0, m_req};
            4'h4: r = 8'h50 | {7'd0, m_ready};
            4'h8: begin
                r = m_mem[m_ptr[7:0]];
                if (cmd[5]) m_ptr = m_ptr + 24'd1;
            end
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic rd(input string tag, input logic [7:0] cmd);
        logic [7:0] rx;
        xfer(cmd, rx);
        chk(tag, rx, prev_exp);
        prev_exp = m_read(cmd);
    endtask

    task automatic wr(input string tag, input logic [7:0] cmd, input logic [7:0] val);
        logic [7:0] rx;
        xfer(cmd, rx);
        chk({tag, " R3 cmd frame"}, rx, prev_exp);
        xfer(val, rx);
        chk({tag, " R3 value frame"}, rx, prev_exp);
        case (cmd[3:0])
            4'h0: m_ptr[7:0]   = val;
            4'h1: m_ptr[15:8]  = val;
            4'h2: m_ptr[23:16] = val;
            4'h3: m_req        = val[0];
            4'h8: begin
                m_mem[m_ptr[7:0]] = val;
                if (cmd[5]) m_ptr = m_ptr + 24'd1;
            end
            default: ;
        endcase
    endtask

    task automatic set_ptr(input logic [23:0] p);
        wr("R2 ptr lo", 8'h00, p[7:0]);
        wr("R2 ptr mid", 8'h01, p[15:8]);
        wr("R2 ptr hi", 8'h02, p[23:16]);
    endtask

    task automatic check_ptr(input string tag);
        rd(tag, 8'h80);
        rd(tag, 8'h81);
        rd(tag, 8'h82);
        rd(tag, 8'h84);
    endtask

    task automatic capture(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cap_we = 1'b1; cap_addr = a; cap_data = d;
        @(negedge clk);
        cap_we = 1'b0;
        if (!m_ready) m_mem[a] = d;
    endtask

    task automatic set_pause(input logic tgt);
        logic [7:0] rx;
        logic [7:0] old_code, new_code;
        bit reached;
        old_code = 8'h50 | {7'd0, m_ready};
        new_code = 8'h50 | {7'd0, tgt};
        wr("R8 control", 8'h03, {7'd0, tgt});
        xfer(8'h84, rx);
        chk("R3 before poll", rx, prev_exp);
        xfer(8'h84, rx);
        chk("R9 status unchanged just after control write", rx, old_code);
        reached = 0;
        for (int n = 0; n < 40 && !reached; n++) begin
            xfer(8'h84, rx);
            if (rx == new_code) reached = 1;
            else chk("R9 status only old code while settling", rx, old_code);
        end
        tests++;
        if (!reached) begin
            fails++;
            $display("FAIL R9 status never settled: actual 0x%02h expected 0x%02h", rx, new_code);
        end
        m_ready  = tgt;
        prev_exp = new_code;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13 reset state
        chk("R13 miso idle after reset", {7'd0, spi_miso}, 8'h00);
        rd("R13 held byte after reset", 8'h84);
        rd("R13 status running after reset", 8'h83);
        rd("R13 control zero after reset", 8'h80);
        rd("R13 ptr lo zero", 8'h81);
        rd("R13 ptr mid zero", 8'h82);
        rd("R13 ptr hi zero", 8'h84);

        // R2 pointer registers
        set_ptr(24'h3C_A5_10);
        check_ptr("R2 pointer readback");
        set_ptr(24'h00_00_10);

        // R5 data writes with and without stepping
        for (int i = 0; i < 4; i++) wr("R5 data write step", 8'h28, 8'hC0 + 8'(i));
        check_ptr("R5 pointer after stepping writes");
        wr("R5 data write hold", 8'h08, 8'h77);
        check_ptr("R5 pointer after plain write");

        // R4 data reads
        set_ptr(24'h00_00_10);
        for (int i = 0; i < 6; i++) rd("R4 data read step", 8'hA8);
        rd("R4 data read hold", 8'h88);
        rd("R4 data read hold again", 8'h88);
        check_ptr("R4 pointer after reads");

        // R7 step bit on other registers
        rd("R7 step bit on ptr lo", 8'hA0);
        wr("R7 step bit on ptr mid write", 8'h21, 8'h02);
        rd("R7 step bit on control", 8'hA3);
        check_ptr("R7 pointer unchanged");

        // R6 wrap
        set_ptr(24'hFF_FF_FF);
        wr("R6 data write at top", 8'h28, 8'h9E);
        check_ptr("R6 pointer wrapped");
        set_ptr(24'hFF_FF_FF);
        rd("R6 read at top", 8'hA8);
        rd("R6 read after wrap", 8'h80);

        // R1 ignored bits, R11 unmapped registers
        rd("R1 bits 6 and 4 ignored", 8'hD0);
        rd("R1 bits 6 and 4 ignored", 8'hC1);
        wr("R11 write unmapped", 8'h05, 8'hAA);
        wr("R11 write unmapped", 8'h4F, 8'h55);
        rd("R11 read unmapped", 8'h85);
        rd("R11 read unmapped", 8'h8F);
        check_ptr("R11 pointer unchanged");

        // R10 capture while running
        capture(8'h30, 8'h5A);
        set_ptr(24'h00_00_30);
        rd("R10 capture while running", 8'h88);
        rd("R10 capture while running", 8'h88);

        // R8/R9 freeze, R10 capture dropped
        set_pause(1'b1);
        rd("R8 control reads request", 8'h83);
        rd("R8 control reads request", 8'h84);
        rd("R9 status paused", 8'h84);
        capture(8'h30, 8'hA5);
        capture(8'h31, 8'h11);
        rd("R10 capture while paused", 8'h88);
        set_ptr(24'h00_00_31);
        rd("R10 capture while paused", 8'hA8);
        rd("R10 capture while paused", 8'h83);

        // release
        set_pause(1'b0);
        rd("R8 control released", 8'h83);
        capture(8'h31, 8'h22);
        set_ptr(24'h00_00_31);
        rd("R10 capture after release", 8'h88);
        rd("R10 capture after release", 8'h84);

        // R12 aborted frames
        xfer_partial(8'h00, 3);
        xfer_partial(8'h28, 7);
        rd("R12 partial frames discarded", 8'h80);
        rd("R12 partial frames discarded", 8'h88);
        rd("R12 partial frames discarded", 8'h84);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule